// File: doc/BRIEF.md
# ISA Byte-Lane Bridge

This bridge turns reads and writes from a 32-bit little-endian CPU local bus into I/O and memory cycles on a 16-bit ISA-style peripheral bus. The peripheral data lines are wired straight across to the low 16 CPU data bits. A byte sent to an odd port therefore arrives on the high lane, while 8-bit devices expect every byte on the low lane. The bridge decodes each request and produces the peripheral port address with A0, the high-byte enable and the read or write strobe. It steers data between the lanes and rejects request shapes that it cannot map.

A 32-bit CPU access is used as an escape for odd ports on 8-bit devices. In the I/O window it produces a single byte cycle to the odd port just above the addressed even port, with the byte on D0-D7. Two I/O address layouts are decoded. The first serves three serial/parallel port blocks, with one port per 32-bit word. The second is a compressed layout for all other ports, where CPU address bit 0 picks the odd port. A memory window uses the compressed layout too. It rejects addresses whose CPU bits 17 and 18 differ, and it performs 32-bit transfers as two 16-bit cycles.

The CPU holds `cpu_valid` and the request fields steady until `cpu_ready` pulses. Every peripheral cycle has one clock of address setup, `STROBE_CLKS` clocks of strobe and one clock of hold.

Top module: `isa_lane_bridge`

## Requirements
- R1: `cpu_ready` is high for exactly one cycle per request. With the request presented before rising edge 1, the pulse is seen after edge STROBE_CLKS+3 for a single-cycle access, after edge 2*STROBE_CLKS+5 for a split access and after edge 1 for a rejected access.
- R2: Every peripheral cycle has the strobe high for exactly STROBE_CLKS clocks. The address and byte enable are stable for one clock before the strobe, during it and in the clock after it.
- R3: A byte access that lands on the low lane drives `isa_bhe` low and moves data on D0-D7. On a read, the byte goes to `cpu_rdata[7:0]` and the other bits are zero. On a write, D8-D15 are driven to zero.
- R4: In the compressed layout, a byte access with CPU address bit 0 set reaches an odd port with `isa_bhe` high and data on D8-D15. On a read, the byte goes to `cpu_rdata[15:8]` and the other bits are zero. On a write, D0-D7 are zero.
- R5: In the I/O window, a 32-bit access in the compressed layout with address bits [1:0] = 00 is a trick cycle. It makes one byte cycle to port {cpu_addr[16:2], 1}, with `isa_bhe` low and `cpu_wdata[7:0]` or the read byte on D0-D7. Read data is {24'b0, D[7:0]}.
- R6: A 16-bit access drives `isa_bhe` high and moves all 16 lines. If the target port is odd, the access is rejected.
- R7: An I/O address whose port = cpu_addr[17:2] falls in one of the eight-port blocks at 0x3F8, 0x2F8 or 0x378 uses the one-port-per-word layout. Only byte and 16-bit accesses with address bits [1:0] = 00 are accepted there. Anything else is rejected.
- R8: Every other address uses the compressed layout, where port = {cpu_addr[16:2], cpu_addr[0]}. An address with bit 1 set is rejected.
- R9: `cpu_addr[19]` = 1 selects memory cycles (`isa_memr`/`isa_memw`), and 0 selects I/O cycles (`isa_ior`/`isa_iow`). A memory address with bit 17 different from bit 18 is rejected.
- R10: In the memory window, a 32-bit access makes two 16-bit cycles. The first goes to the translated port and carries bits [15:0]. The second goes to port + 2 and carries bits [31:16]. An address with bit 0 or bit 2 set is rejected.
- R11: A rejected request, or size code 3, raises `cpu_err` together with `cpu_ready` for one cycle. No strobe rises and the peripheral address does not change.
- R12: During and right after reset, every strobe, `isa_oe`, `cpu_ready` and `cpu_err` is low.
- R13: At most one strobe is high at a time. `isa_oe` is high throughout every write cycle, and it is never high during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Request present; held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| cpu_addr | input | AW | Bit AW-1 selects the memory window; the rest is the window offset |
| cpu_wdata | input | 32 | Write data on natural little-endian lanes |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | High with `cpu_ready` for a rejected request |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| isa_addr | output | PW | Peripheral port or memory address, bit 0 is A0 |
| isa_bhe | output | 1 | High-byte enable (16-bit lane) |
| isa_ior | output | 1 | I/O read strobe |
| isa_iow | output | 1 | I/O write strobe |
| isa_memr | output | 1 | Memory read strobe |
| isa_memw | output | 1 | Memory write strobe |
| isa_dout | output | 16 | Peripheral write data |
| isa_oe | output | 1 | Drive enable for `isa_dout` |
| isa_din | input | 16 | Peripheral read data |

## Verification
The bench builds the bridge with `STROBE_CLKS` = 3 instead of the default 4. Every latency and strobe-width check then depends on the parameter rather than on a hard-coded count, and split transfers stay short enough to run many random requests. Address and port widths stay at their defaults (AW = 20, PW = 16). This keeps CPU bits 17, 18 and 19 inside the address, so the memory-window consistency check and the window select are both reachable. The three serial/parallel blocks stay at their default bases, so random I/O addresses hit both layouts.

// File: rtl/isa_lane_bridge.sv
module isa_lane_bridge #(
  parameter int AW = 20,
  parameter int PW = 16,
  parameter int STROBE_CLKS = 4,
  parameter int MEM_CHK_LO = 17,
  parameter logic [PW-1:0] SIO_A = 16'h03F8,
  parameter logic [PW-1:0] SIO_B = 16'h02F8,
  parameter logic [PW-1:0] SIO_C = 16'h0378
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_valid,
  input  logic          cpu_we,
  input  logic [1:0]    cpu_size,
  input  logic [AW-1:0] cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic          cpu_ready,
  output logic          cpu_err,
  output logic [31:0]   cpu_rdata,
  output logic [PW-1:0] isa_addr,
  output logic          isa_bhe,
  output logic          isa_ior,
  output logic          isa_iow,
  output logic          isa_memr,
  output logic          isa_memw,
  output logic [15:0]   isa_dout,
  output logic          isa_oe,
  input  logic [15:0]   isa_din
);
  localparam int OW = AW - 1;
  localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
  localparam logic [1:0] SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2;
  localparam logic [1:0] K_LO = 2'd0, K_HI = 2'd1, K_HALF = 2'd2, K_SPLIT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD, S_RESP} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic ph, we_r, mem_r, err_r, bhe_r;
  logic [1:0] kind_r;
  logic [PW-1:0] port_r;
  logic [15:0] dout_r, whi_r;
  logic [31:0] rdata_r;

  logic [OW-1:0] off;
  logic is_mem, sio;
  logic [PW-1:0] p0, p1;

  assign off    = cpu_addr[OW-1:0];
  assign is_mem = cpu_addr[AW-1];
  assign p0     = off[PW+1:2];
  assign p1     = {off[PW:2], off[0]};
  assign sio    = !is_mem && ((p0[PW-1:3] == SIO_A[PW-1:3]) ||
                              (p0[PW-1:3] == SIO_B[PW-1:3]) ||
                              (p0[PW-1:3] == SIO_C[PW-1:3]));

  logic d_err, d_bhe;
  logic [1:0] d_kind;
  logic [PW-1:0] d_port;
  logic [15:0] d_dout;

  always_comb begin
    d_err  = 1'b0;
    d_bhe  = 1'b0;
    d_kind = K_LO;
    d_port = p1;
    if (cpu_size == 2'd3) begin
      d_err = 1'b1;
    end else if (sio) begin
      d_port = p0;
      if (cpu_size == SZ_HALF) begin
        d_bhe  = 1'b1;
        d_kind = K_HALF;
      end
      if (off[1:0] != 2'b00 || cpu_size == SZ_WORD || (cpu_size == SZ_HALF && p0[0]))
        d_err = 1'b1;
    end else begin
      if (off[1] || (is_mem && off[MEM_CHK_LO] != off[MEM_CHK_LO+1]))
        d_err = 1'b1;
      case (cpu_size)
        SZ_BYTE: begin
          d_bhe  = off[0];
          d_kind = off[0] ? K_HI : K_LO;
        end
        SZ_HALF: begin
          d_bhe  = 1'b1;
          d_kind = K_HALF;
          if (off[0]) d_err = 1'b1;
        end
        default: begin
          if (off[0]) d_err = 1'b1;
          if (is_mem) begin
            d_bhe  = 1'b1;
            d_kind = K_SPLIT;
            if (off[2]) d_err = 1'b1;
          end else begin
            d_port = {p1[PW-1:1], 1'b1};
          end
        end
      endcase
    end
  end

  always_comb begin
    case (d_kind)
      K_LO:    d_dout = {8'h00, cpu_wdata[7:0]};
      K_HI:    d_dout = {cpu_wdata[15:8], 8'h00};
      default: d_dout = cpu_wdata[15:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      ph      <= 1'b0;
      we_r    <= 1'b0;
      mem_r   <= 1'b0;
      err_r   <= 1'b0;
      bhe_r   <= 1'b0;
      kind_r  <= K_LO;
      port_r  <= '0;
      dout_r  <= '0;
      whi_r   <= '0;
      rdata_r <= '0;
    end else begin
      case (st)
        S_IDLE: if (cpu_valid) begin
          err_r   <= d_err;
          rdata_r <= '0;
          if (d_err) begin
            st <= S_RESP;
          end else begin
            st     <= S_SETUP;
            port_r <= d_port;
            bhe_r  <= d_bhe;
            kind_r <= d_kind;
            we_r   <= cpu_we;
            mem_r  <= is_mem;
            dout_r <= d_dout;
            whi_r  <= cpu_wdata[31:16];
            ph     <= 1'b0;
          end
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_STRB;
        end
        S_STRB: begin
          if (cnt == CW'(STROBE_CLKS - 1)) begin
            st <= S_HOLD;
            if (!we_r) begin
              case (kind_r)
                K_LO:    rdata_r[7:0]  <= isa_din[7:0];
                K_HI:    rdata_r[15:8] <= isa_din[15:8];
                K_HALF:  rdata_r[15:0] <= isa_din;
                default: if (ph) rdata_r[31:16] <= isa_din;
                         else    rdata_r[15:0]  <= isa_din;
              endcase
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (kind_r == K_SPLIT && !ph) begin
            ph     <= 1'b1;
            port_r <= port_r + PW'(2);
            dout_r <= whi_r;
            st     <= S_SETUP;
          end else begin
            st <= S_RESP;
          end
        end
        default: begin
          st    <= S_IDLE;
          err_r <= 1'b0;
        end
      endcase
    end
  end

  logic active, busy;
  assign active    = (st == S_STRB);
  assign busy      = (st == S_SETUP) || (st == S_STRB) || (st == S_HOLD);
  assign isa_ior   = active && !we_r && !mem_r;
  assign isa_iow   = active &&  we_r && !mem_r;
  assign isa_memr  = active && !we_r &&  mem_r;
  assign isa_memw  = active &&  we_r &&  mem_r;
  assign isa_oe    = busy && we_r;
  assign isa_addr  = port_r;
  assign isa_bhe   = bhe_r;
  assign isa_dout  = dout_r;
  assign cpu_ready = (st == S_RESP);
  assign cpu_err   = (st == S_RESP) && err_r;
  assign cpu_rdata = rdata_r;

  logic strb_any;
  logic [CW:0] srun;
  assign strb_any = isa_ior | isa_iow | isa_memr | isa_memw;

  always_ff @(posedge clk) begin
    if (!rst_n) srun <= '0;
    else        srun <= strb_any ? srun + 1'b1 : '0;
  end

  a_r2_setup_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_any) |-> $stable(isa_addr) && $stable(isa_bhe));
  a_r2_strobe_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_any && $past(strb_any)) |-> $stable(isa_addr) && $stable(isa_bhe));
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_any) |-> $stable(isa_addr));
  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_any) |-> srun == (CW+1)'(STROBE_CLKS));
  a_r1_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> cpu_ready && !strb_any && $stable(isa_addr));
  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({isa_ior, isa_iow, isa_memr, isa_memw}));
  a_r13_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_iow || isa_memw) |-> isa_oe);
  a_r13_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_ior || isa_memr) |-> !isa_oe);
endmodule

// File: tb/tb_isa_lane_bridge.sv
`timescale 1ns/1ps
module tb_isa_lane_bridge;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [1:0] cpu_size = 2'd0;
  logic [19:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_ready, cpu_err;
  logic [31:0] cpu_rdata;
  logic [15:0] isa_addr, isa_dout, isa_din;
  logic isa_bhe, isa_ior, isa_iow, isa_memr, isa_memw, isa_oe;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] dev(input logic [15:0] p);
    return {p[7:0] ^ 8'hA5, p[15:8] ^ 8'h3C};
  endfunction

  assign isa_din = dev(isa_addr);

  isa_lane_bridge #(.STROBE_CLKS(W)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
    .isa_addr(isa_addr), .isa_bhe(isa_bhe), .isa_ior(isa_ior), .isa_iow(isa_iow),
    .isa_memr(isa_memr), .isa_memw(isa_memw), .isa_dout(isa_dout),
    .isa_oe(isa_oe), .isa_din(isa_din)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        err;
    logic        split;
    logic [15:0] port;
    logic        bhe;
    logic [1:0]  kind;
    logic [15:0] d0;
    logic [15:0] d1;
    logic [31:0] rd;
  } exp_t;

  function automatic exp_t model(input logic [19:0] a, input logic [1:0] sz, input logic [31:0] wd);
    exp_t e;
    logic mem, sio;
    logic [15:0] p0, p1;
    mem = a[19];
    p0 = a[17:2];
    p1 = {a[16:2], a[0]};
    sio = !mem && (p0[15:3] == 13'h7F || p0[15:3] == 13'h5F || p0[15:3] == 13'h6F);
    e = '0;
    if (sz == 2'd3) e.err = 1'b1;
    else if (sio) begin
      e.port = p0;
      if (a[1:0] != 2'b00 || sz == 2'd2 || (sz == 2'd1 && p0[0])) e.err = 1'b1;
      e.kind = (sz == 2'd1) ? 2'd2 : 2'd0;
    end else begin
      e.port = p1;
      if (a[1] || (mem && a[17] != a[18])) e.err = 1'b1;
      if (sz == 2'd0) e.kind = a[0] ? 2'd1 : 2'd0;
      else if (sz == 2'd1) begin e.kind = 2'd2; if (a[0]) e.err = 1'b1; end
      else begin
        if (a[0]) e.err = 1'b1;
        if (mem) begin e.kind = 2'd3; e.split = 1'b1; if (a[2]) e.err = 1'b1; end
        else begin e.kind = 2'd0; e.port = {p1[15:1], 1'b1}; end
      end
    end
    e.bhe = (e.kind != 2'd0) && !(e.kind == 2'd1 && 1'b0);
    case (e.kind)
      2'd0: begin e.d0 = {8'h00, wd[7:0]};  e.rd = {24'h0, dev(e.port)[7:0]}; end
      2'd1: begin e.d0 = {wd[15:8], 8'h00}; e.rd = {16'h0, dev(e.port)[15:8], 8'h00}; end
      2'd2: begin e.d0 = wd[15:0];          e.rd = {16'h0, dev(e.port)}; end
      default: begin
        e.d0 = wd[15:0]; e.d1 = wd[31:16];
        e.rd = {dev(e.port + 16'd2), dev(e.port)};
      end
    endcase
    return e;
  endfunction

  task automatic txn(input logic [19:0] a, input logic we, input logic [1:0] sz, input logic [31:0] wd);
    exp_t e;
    int lat, ncyc, slen;
    logic prev, any;
    logic [15:0] c_port [2];
    logic [15:0] c_dout [2];
    logic c_bhe [2];
    logic c_oe [2];
    logic [3:0] c_str [2];
    logic [3:0] exp_str;
    logic [15:0] addr_before;
    e = model(a, sz, wd);
    exp_str = a[19] ? (we ? 4'b1000 : 4'b0100) : (we ? 4'b0010 : 4'b0001);
    lat = 0; ncyc = 0; slen = 0; prev = 1'b0;
    addr_before = isa_addr;
    cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd; cpu_valid = 1'b1;
    while (1) begin
      @(negedge clk);
      lat++;
      any = isa_ior | isa_iow | isa_memr | isa_memw;
      if (any) begin
        if (!prev && ncyc < 2) begin
          c_port[ncyc] = isa_addr; c_dout[ncyc] = isa_dout; c_bhe[ncyc] = isa_bhe;
          c_oe[ncyc] = isa_oe; c_str[ncyc] = {isa_memw, isa_memr, isa_iow, isa_ior};
          slen = 0;
        end
        slen++;
      end else if (prev) begin
        chk(slen == W, "R2 strobe width", slen, W);
        ncyc++;
      end
      if (we && any) chk(isa_oe, "R13 oe during write", isa_oe, 1);
      if (!we && busy_rd(any)) chk(!isa_oe, "R13 no oe on read", isa_oe, 0);
      prev = any;
      if (cpu_ready || lat > 100) break;
    end
    cpu_valid = 1'b0;
    chk(cpu_err == e.err, e.err ? "R11 err flag (R6 R7 R8 R9 R10)" : "R11 no err", cpu_err, e.err);
    if (e.err) begin
      chk(lat == 1, "R1 reject latency", lat, 1);
      chk(ncyc == 0, "R11 no cycle on reject", ncyc, 0);
      chk(isa_addr == addr_before, "R11 address unchanged", isa_addr, addr_before);
    end else begin
      chk(lat == (e.split ? 2*W+5 : W+3), "R1 latency", lat, e.split ? 2*W+5 : W+3);
      chk(ncyc == (e.split ? 2 : 1), "R10 cycle count", ncyc, e.split ? 2 : 1);
      if (ncyc >= 1) begin
        chk(c_port[0] == e.port, "R7 R8 R5 port", c_port[0], e.port);
        chk(c_bhe[0] == e.bhe, "R3 R4 R5 R6 bhe", c_bhe[0], e.bhe);
        chk(c_str[0] == exp_str, "R9 strobe kind", c_str[0], exp_str);
        if (we) chk(c_dout[0] == e.d0, "R3 R4 R5 write lanes", c_dout[0], e.d0);
        else    chk(!c_oe[0], "R13 read not driven", c_oe[0], 0);
      end
      if (ncyc == 2) begin
        chk(c_port[1] == e.port + 16'd2, "R10 second port", c_port[1], e.port + 16'd2);
        chk(c_bhe[1], "R10 second bhe", c_bhe[1], 1);
        if (we) chk(c_dout[1] == e.d1, "R10 upper half", c_dout[1], e.d1);
      end
      if (!we) chk(cpu_rdata == e.rd, "R3 R4 R5 R10 read data", cpu_rdata, e.rd);
    end
    @(negedge clk);
    chk(!cpu_ready, "R1 single pulse", cpu_ready, 0);
  endtask

  function automatic logic busy_rd(input logic any);
    return any;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 13579;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk({cpu_ready, cpu_err, isa_ior, isa_iow, isa_memr, isa_memw, isa_oe} == 7'b0,
        "R12 reset quiet", {cpu_ready, cpu_err, isa_ior, isa_iow, isa_memr, isa_memw, isa_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({cpu_ready, cpu_err, isa_ior, isa_iow, isa_memr, isa_memw, isa_oe} == 7'b0,
        "R12 after reset", {cpu_ready, cpu_err, isa_ior, isa_iow, isa_memr, isa_memw, isa_oe}, 0);

    txn(20'h00FE0, 1, 2'd0, 32'h1234_5678); // R7 byte write port 0x3F8
    txn(20'h00BF4, 0, 2'd0, 32'h0);         // R7 byte read port 0x2FD
    txn(20'h00DE8, 0, 2'd1, 32'h0);         // R7 R6 half read port 0x37A
    txn(20'h00DE4, 1, 2'd1, 32'hAAAA_BBBB); // R6 odd port half -> err
    txn(20'h00FE0, 1, 2'd2, 32'h0);         // R7 word in block -> err
    txn(20'h00FE1, 1, 2'd0, 32'h0);         // R7 misaligned -> err
    txn(20'h00440, 1, 2'd0, 32'hCAFE_F00D); // R3 even byte port 0x220
    txn(20'h00441, 1, 2'd0, 32'hCAFE_F00D); // R4 odd byte port 0x221
    txn(20'h00441, 0, 2'd0, 32'h0);         // R4 odd byte read
    txn(20'h004F0, 1, 2'd2, 32'h0000_0077); // R5 trick write port 0x279
    txn(20'h00404, 0, 2'd2, 32'h0);         // R5 trick read port 0x203
    txn(20'h007C0, 0, 2'd1, 32'h0);         // R6 half port 0x3E0
    txn(20'h007C1, 0, 2'd1, 32'h0);         // R6 odd half -> err
    txn(20'h00442, 0, 2'd0, 32'h0);         // R8 bit1 -> err
    txn(20'h80010, 0, 2'd2, 32'h0);         // R10 split read
    txn(20'h80010, 1, 2'd2, 32'h9876_5432); // R10 split write
    txn(20'h80014, 1, 2'd2, 32'h0);         // R10 misaligned -> err
    txn(20'hA0000, 0, 2'd0, 32'h0);         // R9 bit17 != bit18 -> err
    txn(20'hE0001, 1, 2'd0, 32'h0000_5500); // R9 both set, memory odd byte
    txn(20'h00440, 0, 2'd3, 32'h0);         // R11 reserved size

    for (int i = 0; i < 300; i++) begin
      logic [19:0] a;
      int cls;
      cls = $urandom_range(0, 2);
      a = 20'($urandom);
      if (cls == 0) begin
        a[19] = 1'b0;
        a[17:2] = {$urandom_range(0, 2) == 0 ? 13'h7F : ($urandom_range(0, 1) ? 13'h5F : 13'h6F), 3'($urandom)};
        if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      end else if (cls == 1) begin
        a[19] = 1'b0;
        if ($urandom_range(0, 3) != 0) a[1] = 1'b0;
      end else begin
        a[19] = 1'b1;
        if ($urandom_range(0, 3) != 0) a[18] = a[17];
        if ($urandom_range(0, 3) != 0) a[1] = 1'b0;
      end
      txn(a, 1'($urandom), 2'($urandom_range(0, 3)), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule